// File: doc/BRIEF.md
# Phase-Offset Two-Pulse Gate Driver

This block drives a power switch through a pulse transformer. Only narrow pulses are sent: a charge pulse turns the gate on and a discharge pulse turns it off. Two counters run at the same fixed period. Each counter opens its own fixed pulse window in the last `PW` ticks of its count. The discharge counter produces the discharge pulse and the charge counter produces the charge pulse. The duty cycle therefore depends only on how far the charge counter leads the discharge counter. No compare threshold ever moves.

A phase request is presented on `offset_req` and is captured by a one-cycle `offset_load` strobe. The request is held until the next wrap of the discharge counter, and it is applied to the charge counter at that wrap. After one application the update path disarms until another strobe arrives. When `enable` rises, the discharge counter starts at the beginning of its pulse window, so the first pulse issued is a discharge pulse. The defaults (2400-tick period, 48-tick width) give 20 kHz pulses that are 1 µs wide at a 48 MHz clock.

Top module: `two_pulse_gate_drv`

## Requirements
- R1: While reset is asserted, and from the first clock edge at which `enable` is sampled low, both `charge_pulse` and `discharge_pulse` are low.
- R2: On the first edge at which `enable` is sampled high after being low, `discharge_pulse` goes high and stays high for `PW` cycles. No charge pulse appears before that discharge pulse.
- R3: While enabled, `discharge_pulse` is high for `PW` consecutive cycles, and it rises again every `PERIOD` cycles.
- R4: With an applied offset D where PW ≤ D ≤ PERIOD−PW, `charge_pulse` is high for `PW` cycles and rises exactly D cycles before each discharge pulse rises. This gives an on-time of D/PERIOD (for example, 25 % for D = PERIOD/4 and 75 % for D = 3·PERIOD/4).
- R5: A strobed offset changes the charge timing only from the cycle after the discharge counter wraps (the cycle in which the discharge pulse ends). Charge pulses before that wrap keep the previous offset.
- R6: If several strobes arrive before a wrap, only the last value is applied. A strobe in the same cycle as a wrap stays pending for the following wrap.
- R7: A requested offset above PERIOD−1 is applied as PERIOD−1.
- R8: An applied offset remains in force for every following period until a new strobe arrives. The first wrap after enable applies either the pending request or, if no request is pending, the last applied offset (0 after reset).
- R9: The charge pulse starts only when the charge counter steps exactly onto the first tick of its window, and it is forced low while the discharge pulse is high. An offset of 0 therefore produces no charge pulses.
- R10: Disabling and then re-enabling restarts with a discharge pulse first and keeps the last applied offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Run enable; outputs are held low while it is low |
| offset_req | input | OW | Requested phase lead of the charge counter, in ticks |
| offset_load | input | 1 | One-cycle strobe that captures `offset_req` |
| charge_pulse | output | 1 | Gate charge (turn-on) pulse |
| discharge_pulse | output | 1 | Gate discharge (turn-off) pulse |

## Verification
An offset applied at the wrong moment shows up within one period as a charge pulse that is too early or too late relative to the next discharge edge. A lost or stale pending flag shows up as a request that never takes effect, or as one that is applied twice. A start alignment that is wrong appears on the very first active cycle, as a missing discharge pulse or a charge pulse that comes first. The bench runs a cycle-by-cycle timing model against the port values, and it also measures the charge-to-discharge spacing at the 25 % and 75 % settings.

// File: rtl/two_pulse_gate_drv.sv
module two_pulse_gate_drv #(
  parameter int PERIOD = 2400,
  parameter int PW     = 48,
  parameter int OW     = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic [OW-1:0] offset_req,
  input  logic          offset_load,
  output logic          charge_pulse,
  output logic          discharge_pulse
);
  localparam int CW = $clog2(PERIOD);
  localparam logic [CW-1:0] LAST   = CW'(PERIOD - 1);
  localparam logic [CW-1:0] WSTART = CW'(PERIOD - PW);
  localparam logic [OW-1:0] OMAX   = OW'(PERIOD - 1);

  logic          active, run_b, pend, cwin;
  logic [CW-1:0] ca, cb, pval, act_off;

  wire [CW-1:0] req_c = (offset_req > OMAX) ? LAST : offset_req[CW-1:0];
  wire          wrap  = enable && active && (ca == LAST);
  wire          load  = wrap && (pend || !run_b);
  wire [CW-1:0] nval  = pend ? pval : act_off;
  wire [CW-1:0] cb_nx = (cb == LAST) ? '0 : cb + 1'b1;

  assign discharge_pulse = active && (ca >= WSTART);
  assign charge_pulse    = cwin && !discharge_pulse;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active  <= 1'b0;
      run_b   <= 1'b0;
      cwin    <= 1'b0;
      ca      <= WSTART;
      cb      <= '0;
      act_off <= '0;
    end else if (!enable) begin
      active <= 1'b0;
      run_b  <= 1'b0;
      cwin   <= 1'b0;
      ca     <= WSTART;
      cb     <= '0;
    end else if (!active) begin
      active <= 1'b1;
    end else begin
      ca <= wrap ? '0 : ca + 1'b1;
      if (load) begin
        cb      <= nval;
        act_off <= nval;
        run_b   <= 1'b1;
        cwin    <= (nval == WSTART);
      end else begin
        cb   <= cb_nx;
        cwin <= run_b && ((cb_nx == WSTART) || (cwin && cb_nx != '0));
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend <= 1'b0;
      pval <= '0;
    end else begin
      if (load) pend <= 1'b0;
      if (offset_load) begin
        pend <= 1'b1;
        pval <= req_c;
      end
    end
  end
endmodule

// File: rtl/two_pulse_gate_drv_chk.sv
module two_pulse_gate_drv_chk #(
  parameter int PERIOD = 2400,
  parameter int PW     = 48
) (
  input logic clk,
  input logic rst_n,
  input logic enable,
  input logic charge_pulse,
  input logic discharge_pulse
);
  logic dis_q, seen;
  int   gap;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dis_q <= 1'b0;
      seen  <= 1'b0;
      gap   <= 0;
    end else begin
      dis_q <= discharge_pulse;
      if (!enable) seen <= 1'b0;
      if (discharge_pulse && !dis_q) begin
        gap <= 1;
        if (enable) seen <= 1'b1;
      end else begin
        gap <= gap + 1;
      end
    end
  end

  a_r1_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!charge_pulse && !discharge_pulse));

  a_r2_discharge_first: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(enable) |=> (discharge_pulse && !charge_pulse));

  a_r3_width: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && $rose(discharge_pulse)) |=> discharge_pulse);

  a_r3_period: assert property (@(posedge clk) disable iff (!rst_n)
    (discharge_pulse && !dis_q && seen && enable) |-> (gap == PERIOD));
endmodule

bind two_pulse_gate_drv two_pulse_gate_drv_chk #(.PERIOD(PERIOD), .PW(PW)) u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable),
  .charge_pulse(charge_pulse), .discharge_pulse(discharge_pulse));

// File: tb/two_pulse_gate_drv_bench.sv
module two_pulse_gate_drv_bench;
  localparam int P  = 400;
  localparam int PW = 16;
  localparam int OW = 16;

  logic clk = 1'b0, rst_n = 1'b0, enable = 1'b0, offset_load = 1'b0;
  logic [OW-1:0] offset_req = '0;
  logic charge_pulse, discharge_pulse;
  int total = 0, fails = 0;
  string tag = "R1";

  always #5 clk = ~clk;

  two_pulse_gate_drv #(.PERIOD(P), .PW(PW), .OW(OW)) u_two_pulse_gate_drv (
    .clk(clk), .rst_n(rst_n), .enable(enable), .offset_req(offset_req),
    .offset_load(offset_load), .charge_pulse(charge_pulse),
    .discharge_pulse(discharge_pulse));

  task automatic check(input logic ok, input string t, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", t, act, exp);
    end
  endtask

  // behavioural timing model
  bit m_act, pend, inwin, loaded;
  int t, d_cur, d_last, pval, phase, cb;
  bit exp_d, exp_c;

  always @(posedge clk) begin
    loaded = 0;
    if (!rst_n) begin
      m_act = 0; d_last = 0; pend = 0; inwin = 0; d_cur = -1; t = 0;
    end else begin
      if (!enable) begin
        m_act = 0; t = 0; d_cur = -1; inwin = 0;
      end else if (!m_act) begin
        m_act = 1; t = 0;
      end else begin
        t++;
        phase = (t + P - PW) % P;
        if (phase == 0 && (pend || d_cur < 0)) begin
          d_cur = pend ? pval : d_last;
          d_last = d_cur; pend = 0; loaded = 1;
        end
        if (d_cur >= 0) begin
          cb = (d_cur + phase) % P;
          inwin = (cb == P - PW) || (inwin && cb != 0 && !loaded);
        end
      end
      if (offset_load) begin
        pend = 1;
        pval = (offset_req > P - 1) ? P - 1 : int'(offset_req);
      end
    end
    phase = (t + P - PW) % P;
    exp_d = m_act && phase >= P - PW;
    exp_c = m_act && d_cur >= 0 && inwin && !exp_d;
  end

  always @(negedge clk) begin
    if (rst_n) begin
      check(discharge_pulse === exp_d, {tag, " discharge"}, discharge_pulse, exp_d);
      check(charge_pulse === exp_c, {tag, " charge"}, charge_pulse, exp_c);
    end
  end

  task automatic req(input int v);
    @(negedge clk); offset_req = OW'(v); offset_load = 1'b1;
    @(negedge clk); offset_load = 1'b0;
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wait_dis_end;
    while (!discharge_pulse) @(negedge clk);
    while (discharge_pulse) @(negedge clk);
  endtask

  task automatic spacing(input int exp, input string t2);
    int n;
    while (charge_pulse) @(negedge clk);
    while (!charge_pulse) @(negedge clk);
    n = 0;
    while (!discharge_pulse) begin @(negedge clk); n++; end
    check(n == exp, t2, n, exp);
  endtask

  initial begin
    #2_000_000;
    fails++; total++;
    $display("FAIL watchdog: actual 0 expected 1");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    tag = "R1 reset";
    cycles(3);
    check(!charge_pulse && !discharge_pulse, "R1 reset low", charge_pulse, 0);
    rst_n = 1'b1;
    cycles(2);
    req(100);
    tag = "R2 start";
    @(negedge clk); enable = 1'b1;
    @(negedge clk);
    check(discharge_pulse === 1'b1, "R2 first pulse discharge", discharge_pulse, 1);
    check(charge_pulse === 1'b0, "R2 no charge first", charge_pulse, 0);
    tag = "R3 R4 25pct";
    spacing(100, "R4 25pct spacing");
    cycles(3 * P);
    tag = "R5 update";
    cycles(50);
    req(300);
    wait_dis_end;
    spacing(300, "R4 75pct spacing");
    tag = "R8 persist";
    spacing(300, "R8 offset persists");
    tag = "R6 overwrite";
    cycles(30);
    req(50); req(200);
    wait_dis_end;
    spacing(200, "R6 last request wins");
    tag = "R7 clamp";
    req(5000);
    wait_dis_end;
    cycles(2 * P);
    tag = "R9 zero";
    req(0);
    wait_dis_end;
    cycles(2 * P);
    tag = "R9 entry";
    req(390);
    wait_dis_end;
    cycles(2 * P);
    req(120);
    wait_dis_end;
    cycles(P);
    tag = "R1 disable";
    @(negedge clk); enable = 1'b0;
    @(negedge clk);
    check(!charge_pulse && !discharge_pulse, "R1 disabled low", discharge_pulse, 0);
    cycles(20);
    tag = "R10 restart";
    @(negedge clk); enable = 1'b1;
    @(negedge clk);
    check(discharge_pulse === 1'b1, "R10 discharge first again", discharge_pulse, 1);
    spacing(120, "R10 offset kept");
    cycles(P);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule